// File: doc/BRIEF.md
# Page-Granular Memory Firewall Filter

This block sits beside a small on-chip memory and decides, for every bus request that falls into the memory's address window, whether that request may proceed. The window is cut into 4 KiB pages. Each page carries its own security setting, a default privilege setting and an optional compartment filter. When the filter is on, each compartment identifier (CID) has its own read, write and privilege page bitmaps.

The decision is combinational: it is made in the same cycle as the request. A granted read passes the memory's data through and a granted write enables the memory write strobe. A denied request returns zero data, drives no write strobe and raises a one-cycle error. The first denied request is recorded: a sticky flag is set, and the full address and a short syndrome are captured. They stay frozen until software clears the flag. All rules live in a simple word-addressed register port. A lock register freezes the page and compartment rules; a write attempted while locked is refused and raises a configuration error flag.

Top module: `page_fw_filter`

## Requirements
- R1: After reset every rule is zero, so any in-window request that is non-secure is granted, whether privileged or not. Status, control and lock read zero.
- R2: The page index is (address − WIN_BASE) >> 12. A request below WIN_BASE, or at or above WIN_BASE + NPAGE·4096, is denied.
- R3: A page counts as secure when its security register is nonzero. A request whose secure attribute differs from the page is denied. The exception is a secure request while control bit 31 (register 0x000) is set; that request passes this check.
- R4: With the page's CID filter off (CID-config bit 0 clear), an unprivileged request is denied when the page's privilege register is nonzero. No CID check applies.
- R5: With the page's CID filter on, a read needs bit <page> of the requester's read bitmap and a write needs bit <page> of its write bitmap. A CID of 7 or above is denied.
- R6: With the page's CID filter on and bit <page> set in the requester's privilege bitmap, only a privileged request is allowed.
- R7: A denied request gives acc_err high, acc_grant low, acc_rdata zero and mem_we low, all in the request cycle. A granted request gives acc_rdata = mem_rdata, and mem_we = 1 for a write.
- R8: A denial while the illegal flag is clear sets that flag (status bit 1). It also captures the address (0x024) and the syndrome (0x020) = {write[5], privileged[4], secure[3], cid[2:0]}. Later denials leave both captured values unchanged until the flag is cleared.
- R9: The clear register (0x00C) is write-1-to-clear: bit 0 clears the configuration error flag and bit 1 clears the illegal flag. Status (0x008) reads {30'b0, illegal, config_error}.
- R10: While the lock register (0x010) holds a nonzero value, writes to the page or bitmap registers are ignored and set the configuration error flag. Control, lock and clear stay writable.
- R11: Security and privilege registers keep bits 7:0. CID-config registers keep bits 0, 2 and 6:4 (mask 0x75). Bitmaps keep bits NPAGE−1:0. Every other bit reads zero.
- R12: Register map:
  - security at 0x100 + 4·page
  - privilege at 0x200 + 4·page
  - CID config at 0xA00 + 4·page
  - privilege bitmap at 0x800 + 0x20·cid
  - read bitmap at 0x808 + 0x20·cid
  - write bitmap at 0x810 + 0x20·cid

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address (also selects read-back) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read-back of cfg_addr |
| acc_valid | input | 1 | Memory request present |
| acc_addr | input | 32 | Request byte address |
| acc_write | input | 1 | Request is a write |
| acc_priv | input | 1 | Request is privileged |
| acc_sec | input | 1 | Request is secure |
| acc_cid | input | 3 | Requester compartment ID |
| mem_rdata | input | 32 | Read data from the memory |
| acc_grant | output | 1 | Request allowed |
| acc_err | output | 1 | Request denied (error response) |
| acc_rdata | output | 32 | Read data returned to the requester |
| mem_we | output | 1 | Write strobe to the memory |

## Verification
Some properties are checked on every cycle:
- a denial always returns zero data with no write strobe;
- an out-of-window request and a security mismatch without the relax bit never grant;
- the first denial is captured with its address;
- the captured values stay frozen while the flag is held;
- a locked write leaves every rule unchanged and raises the configuration error.

Only the bench's scenarios can show the rest. That covers the full grant decision across the combinations of filter, bitmaps, privilege and CID, the field masks and map offsets seen on read-back, and the write-1-to-clear sequencing of both flags.

// File: rtl/page_fw_filter.sv
module page_fw_filter #(
  parameter int          NPAGE      = 32,
  parameter int          NCID       = 7,
  parameter logic [31:0] WIN_BASE   = 32'h0002_0000,
  parameter int          PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_write,
  input  logic        acc_priv,
  input  logic        acc_sec,
  input  logic [2:0]  acc_cid,
  input  logic [31:0] mem_rdata,
  output logic        acc_grant,
  output logic        acc_err,
  output logic [31:0] acc_rdata,
  output logic        mem_we
);
  localparam int          PW       = (NPAGE > 1) ? $clog2(NPAGE) : 1;
  localparam logic [31:0] WIN_SIZE = 32'(NPAGE) << PAGE_SHIFT;

  logic [NPAGE-1:0][7:0]      sec_q, prv_q;
  logic [NPAGE-1:0][6:0]      cidc_q;
  logic [NCID-1:0][NPAGE-1:0] rdm_q, wrm_q, pvm_q;
  logic                       relax_q, cfg_err_q, ill_q;
  logic [31:0]                lock_q, faddr_q;
  logic [5:0]                 fsyn_q;

  // request decision
  logic [31:0]   off;
  logic [PW-1:0] page;
  logic          in_win, cid_ok, pg_sec, pg_prv, cf_en;
  logic          sec_ok, flt_ok, base_ok, allow;
  logic [2:0]    cid_ix;

  assign off     = acc_addr - WIN_BASE;
  assign in_win  = (acc_addr >= WIN_BASE) && (off < WIN_SIZE);
  assign page    = off[PAGE_SHIFT +: PW];
  assign cid_ok  = {29'd0, acc_cid} < NCID;
  assign cid_ix  = cid_ok ? acc_cid : 3'd0;
  assign pg_sec  = |sec_q[page];
  assign pg_prv  = |prv_q[page];
  assign cf_en   = cidc_q[page][0];
  assign sec_ok  = (acc_sec == pg_sec) || (acc_sec && relax_q);
  assign base_ok = acc_priv || !pg_prv;
  assign flt_ok  = cid_ok
                && (acc_write ? wrm_q[cid_ix][page] : rdm_q[cid_ix][page])
                && (acc_priv || !pvm_q[cid_ix][page]);
  assign allow   = in_win && sec_ok && (cf_en ? flt_ok : base_ok);

  assign acc_grant = acc_valid && allow;
  assign acc_err   = acc_valid && !allow;
  assign acc_rdata = acc_grant ? mem_rdata : 32'd0;
  assign mem_we    = acc_grant && acc_write;

  // register decode
  logic          hit_ctrl, hit_stat, hit_clr, hit_lock, hit_syn, hit_fad;
  logic          hit_sec, hit_prv, hit_cidc, hit_map, cfg_prot, wr_ok, lock_err;
  logic          pg_in, cid_in, sub_ok;
  logic [PW-1:0] pw;
  logic [2:0]    mc;
  logic [4:0]    sub;

  assign pg_in    = ({26'd0, cfg_addr[7:2]} < NPAGE) && (cfg_addr[1:0] == 2'b00);
  assign pw       = cfg_addr[2 +: PW];
  assign mc       = cfg_addr[7:5];
  assign sub      = cfg_addr[4:0];
  assign cid_in   = {29'd0, mc} < NCID;
  assign sub_ok   = (sub == 5'h00) || (sub == 5'h08) || (sub == 5'h10);
  assign hit_ctrl = cfg_addr == 12'h000;
  assign hit_stat = cfg_addr == 12'h008;
  assign hit_clr  = cfg_addr == 12'h00C;
  assign hit_lock = cfg_addr == 12'h010;
  assign hit_syn  = cfg_addr == 12'h020;
  assign hit_fad  = cfg_addr == 12'h024;
  assign hit_sec  = (cfg_addr[11:8] == 4'h1) && pg_in;
  assign hit_prv  = (cfg_addr[11:8] == 4'h2) && pg_in;
  assign hit_cidc = (cfg_addr[11:8] == 4'hA) && pg_in;
  assign hit_map  = (cfg_addr[11:8] == 4'h8) && cid_in && sub_ok;
  assign cfg_prot = hit_sec || hit_prv || hit_cidc || hit_map;
  assign wr_ok    = cfg_wr && (lock_q == 32'd0);
  assign lock_err = cfg_wr && cfg_prot && (lock_q != 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= '0;
      prv_q     <= '0;
      cidc_q    <= '0;
      rdm_q     <= '0;
      wrm_q     <= '0;
      pvm_q     <= '0;
      relax_q   <= 1'b0;
      lock_q    <= '0;
      cfg_err_q <= 1'b0;
      ill_q     <= 1'b0;
      faddr_q   <= '0;
      fsyn_q    <= '0;
    end else begin
      if (cfg_wr && hit_ctrl) relax_q <= cfg_wdata[31];
      if (cfg_wr && hit_lock) lock_q  <= cfg_wdata;
      if (wr_ok && hit_sec)   sec_q[pw]  <= cfg_wdata[7:0];
      if (wr_ok && hit_prv)   prv_q[pw]  <= cfg_wdata[7:0];
      if (wr_ok && hit_cidc)  cidc_q[pw] <= cfg_wdata[6:0] & 7'h75;
      if (wr_ok && hit_map) begin
        case (sub)
          5'h00:   pvm_q[mc] <= cfg_wdata[NPAGE-1:0];
          5'h08:   rdm_q[mc] <= cfg_wdata[NPAGE-1:0];
          default: wrm_q[mc] <= cfg_wdata[NPAGE-1:0];
        endcase
      end
      cfg_err_q <= (cfg_err_q && !(cfg_wr && hit_clr && cfg_wdata[0])) || lock_err;
      if (acc_err && !ill_q) begin
        ill_q   <= 1'b1;
        faddr_q <= acc_addr;
        fsyn_q  <= {acc_write, acc_priv, acc_sec, acc_cid};
      end else if (cfg_wr && hit_clr && cfg_wdata[1]) begin
        ill_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata = 32'd0;
    if (hit_ctrl)      cfg_rdata = {relax_q, 31'd0};
    else if (hit_stat) cfg_rdata = {30'd0, ill_q, cfg_err_q};
    else if (hit_lock) cfg_rdata = lock_q;
    else if (hit_syn)  cfg_rdata = {26'd0, fsyn_q};
    else if (hit_fad)  cfg_rdata = faddr_q;
    else if (hit_sec)  cfg_rdata = {24'd0, sec_q[pw]};
    else if (hit_prv)  cfg_rdata = {24'd0, prv_q[pw]};
    else if (hit_cidc) cfg_rdata = {25'd0, cidc_q[pw]};
    else if (hit_map) begin
      case (sub)
        5'h00:   cfg_rdata[NPAGE-1:0] = pvm_q[mc];
        5'h08:   cfg_rdata[NPAGE-1:0] = rdm_q[mc];
        default: cfg_rdata[NPAGE-1:0] = wrm_q[mc];
      endcase
    end
  end

  a_r7_deny_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == 32'd0) && !mem_we && !acc_grant);
  a_r2_outside_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_win) |-> acc_err);
  a_r3_sec_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_sec != pg_sec) && !(acc_sec && relax_q)) |-> !acc_grant);
  a_r8_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !ill_q) |=> ill_q && (faddr_q == $past(acc_addr)));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q && !(cfg_wr && hit_clr && cfg_wdata[1])) |=>
      ill_q && $stable(faddr_q) && $stable(fsyn_q));
  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_prot && (lock_q != 32'd0)) |=>
      cfg_err_q && $stable(sec_q) && $stable(prv_q) && $stable(cidc_q)
      && $stable(rdm_q) && $stable(wrm_q) && $stable(pvm_q));
endmodule

// File: tb/sim_page_fw_filter.sv
module sim_page_fw_filter;
  localparam logic [31:0] BASE = 32'h0002_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0, acc_sec = 1'b0;
  logic [31:0] acc_addr = '0, mem_rdata = '0, acc_rdata;
  logic [2:0]  acc_cid = '0;
  logic        acc_grant, acc_err, mem_we;

  int nchk = 0, nfail = 0;
  bit done = 0;

  page_fw_filter u0 (.*);

  always #10 clk = ~clk;

  logic [7:0]  m_sec [32];
  logic [7:0]  m_prv [32];
  logic [6:0]  m_cidc[32];
  logic [31:0] m_rd[7], m_wr[7], m_pv[7];
  logic [31:0] m_lock, m_fa;
  logic [5:0]  m_fs;
  bit          m_relax, m_cfe, m_ill;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_prot(logic [11:0] a);
    if (a >= 12'h100 && a < 12'h180) return 1;
    if (a >= 12'h200 && a < 12'h280) return 1;
    if (a >= 12'hA00 && a < 12'hA80) return 1;
    if (a >= 12'h800 && a < 12'h8E0 && (a[4:0] == 0 || a[4:0] == 8 || a[4:0] == 16)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    int p = int'(a[6:2]);
    int c = int'(a[7:5]);
    if (a == 12'h000) return {m_relax, 31'd0};
    if (a == 12'h008) return {30'd0, m_ill, m_cfe};
    if (a == 12'h010) return m_lock;
    if (a == 12'h020) return {26'd0, m_fs};
    if (a == 12'h024) return m_fa;
    if (a[11:8] == 4'h1) return {24'd0, m_sec[p]};
    if (a[11:8] == 4'h2) return {24'd0, m_prv[p]};
    if (a[11:8] == 4'hA) return {25'd0, m_cidc[p]};
    if (a[4:0] == 0) return m_pv[c];
    if (a[4:0] == 8) return m_rd[c];
    return m_wr[c];
  endfunction

  task automatic cw(logic [11:0] a, logic [31:0] d);
    int p = int'(a[6:2]);
    int c = int'(a[7:5]);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (a == 12'h000) m_relax = d[31];
    if (a == 12'h010) m_lock = d;
    if (a == 12'h00C) begin
      if (d[0]) m_cfe = 0;
      if (d[1]) m_ill = 0;
    end
    if (is_prot(a)) begin
      if (m_lock != 0) m_cfe = 1;
      else if (a[11:8] == 4'h1) m_sec[p] = d[7:0];
      else if (a[11:8] == 4'h2) m_prv[p] = d[7:0];
      else if (a[11:8] == 4'hA) m_cidc[p] = d[6:0] & 7'h75;
      else if (a[4:0] == 0) m_pv[c] = d;
      else if (a[4:0] == 8) m_rd[c] = d;
      else m_wr[c] = d;
    end
  endtask

  task automatic crd(logic [11:0] a, string req);
    @(negedge clk);
    cfg_addr = a;
    #2;
    chk(req, cfg_rdata, mread(a));
  endtask

  function automatic bit exp_ok(logic [31:0] a, bit w, bit p, bit s, logic [2:0] c);
    int pg;
    bit sc;
    if (a < BASE || a >= BASE + 32'h0002_0000) return 0;
    pg = int'((a - BASE) >> 12);
    sc = m_sec[pg] != 0;
    if (s != sc && !(s && m_relax)) return 0;
    if (!m_cidc[pg][0]) return p || (m_prv[pg] == 0);
    if (c >= 7) return 0;
    if (w ? !m_wr[c][pg] : !m_rd[c][pg]) return 0;
    if (m_pv[c][pg] && !p) return 0;
    return 1;
  endfunction

  task automatic acc(logic [31:0] a, bit w, bit p, bit s, logic [2:0] c, string req);
    bit e;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_priv = p; acc_sec = s; acc_cid = c;
    mem_rdata = $urandom;
    #2;
    e = exp_ok(a, w, p, s, c);
    chk({req, " grant"}, {31'd0, acc_grant}, {31'd0, e});
    chk("R7 err", {31'd0, acc_err}, {31'd0, !e});
    chk("R7 rdata", acc_rdata, e ? mem_rdata : 32'd0);
    chk("R7 mem_we", {31'd0, mem_we}, {31'd0, e && w});
    @(posedge clk);
    if (!e && !m_ill) begin
      m_ill = 1; m_fa = a; m_fs = {w, p, s, c};
    end
    #1 acc_valid = 0;
  endtask

  function automatic logic [31:0] pa(int pg);
    return BASE + 32'(pg) * 32'd4096 + 32'($urandom % 4096);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    for (int i = 0; i < 32; i++) begin m_sec[i] = 0; m_prv[i] = 0; m_cidc[i] = 0; end
    for (int i = 0; i < 7; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_pv[i] = 0; end
    m_lock = 0; m_fa = 0; m_fs = 0; m_relax = 0; m_cfe = 0; m_ill = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    crd(12'h008, "R1 status");
    crd(12'h000, "R1 ctrl");
    crd(12'h010, "R1 lock");
    acc(pa(0), 0, 0, 0, 0, "R1 read");
    acc(pa(31), 1, 1, 0, 5, "R1 write");

    // R11 / R12 masks and map
    cw(12'h100 + 12'd12, 32'hFFFF_FFFF); crd(12'h10C, "R11 sec mask");
    cw(12'h200 + 12'd20, 32'hFFFF_FF5A); crd(12'h214, "R11 prv mask");
    cw(12'hA00 + 12'd20, 32'hFFFF_FFFF); crd(12'hA14, "R11 cidc mask");
    cw(12'h808 + 12'h040, 32'hDEAD_BEEF); crd(12'h848, "R12 read map cid2");
    crd(12'h840, "R12 priv map cid2 untouched");
    crd(12'h850, "R12 write map cid2 untouched");
    cw(12'h10C, 0); cw(12'h214, 0); cw(12'hA14, 0); cw(12'h848, 0);

    // R3 security and R8 capture
    cw(12'h100 + 12'd12, 32'h1);
    acc(pa(3), 0, 1, 0, 1, "R3 nonsec to secure page");
    crd(12'h008, "R8 flag set");
    crd(12'h024, "R8 fault address");
    crd(12'h020, "R8 syndrome");
    acc(pa(3) ^ 32'h4, 1, 0, 0, 4, "R3 second fault");
    crd(12'h024, "R8 address held");
    crd(12'h020, "R8 syndrome held");
    cw(12'h00C, 32'h2); crd(12'h008, "R9 clear illegal");
    acc(pa(3), 0, 0, 1, 0, "R3 secure to secure page");
    acc(pa(4), 1, 0, 1, 0, "R3 secure to nonsec page");
    cw(12'h000, 32'h8000_0000); crd(12'h000, "R3 ctrl readback");
    acc(pa(4), 1, 0, 1, 0, "R3 relax secure");
    acc(pa(3), 0, 0, 0, 0, "R3 relax keeps nonsec deny");
    cw(12'h000, 0); cw(12'h00C, 32'h3);

    // R4 default privilege
    cw(12'h200 + 12'd24, 32'h10);
    acc(pa(6), 0, 0, 0, 0, "R4 unpriv denied");
    acc(pa(6), 1, 1, 0, 0, "R4 priv ok");

    // R5 / R6 CID filter
    cw(12'hA00 + 12'd28, 32'h1);
    cw(12'h808 + 12'h040, 32'h80);
    acc(pa(7), 0, 0, 0, 2, "R5 read allowed");
    acc(pa(7), 1, 0, 0, 2, "R5 write not in map");
    acc(pa(7), 0, 0, 0, 3, "R5 other cid");
    acc(pa(7), 0, 1, 0, 7, "R5 cid7");
    cw(12'h800 + 12'h040, 32'h80);
    acc(pa(7), 0, 0, 0, 2, "R6 unpriv denied");
    acc(pa(7), 0, 1, 0, 2, "R6 priv ok");
    cw(12'h00C, 32'h3);

    // R2 window edges
    acc(BASE - 32'd4, 0, 1, 0, 0, "R2 below window");
    acc(BASE + 32'h0002_0000, 0, 1, 0, 0, "R2 above window");
    acc(BASE + 32'h0001_FFFC, 0, 1, 0, 0, "R2 last word");
    cw(12'h00C, 32'h3);

    // R10 lock
    cw(12'h010, 32'h1);
    cw(12'h100 + 12'd36, 32'hFF);
    crd(12'h124, "R10 locked write ignored");
    crd(12'h008, "R10 cfg error flag");
    acc(pa(9), 0, 0, 0, 0, "R10 page still open");
    cw(12'h000, 32'h8000_0000); crd(12'h000, "R10 ctrl writable");
    cw(12'h00C, 32'h1); crd(12'h008, "R9 clear cfg error");
    cw(12'h010, 0); cw(12'h000, 0);

    // random phase
    for (int it = 0; it < 800; it++) begin
      int k = $urandom % 10;
      if (k < 3) begin
        int kind = $urandom % 5;
        logic [11:0] a;
        logic [31:0] d = $urandom;
        case (kind)
          0: a = 12'h000;
          1: begin a = 12'h100 + 12'(4 * ($urandom % 32)); if ($urandom % 3 != 0) d = 0; end
          2: begin a = 12'h200 + 12'(4 * ($urandom % 32)); if ($urandom % 3 != 0) d = 0; end
          3: a = 12'hA00 + 12'(4 * ($urandom % 32));
          default: a = 12'h800 + 12'(32 * ($urandom % 7)) + 12'(8 * ($urandom % 3));
        endcase
        cw(a, d);
        crd(a, "R11 R12 random readback");
      end else begin
        logic [31:0] a = ($urandom % 16 == 0) ? (BASE - 32'd8 + (($urandom % 2) * 32'h0002_0008))
                                               : pa($urandom % 32);
        acc(a, 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), "R3 R4 R5 R6 random");
      end
      if (it % 25 == 24) begin
        crd(12'h008, "R8 random status");
        crd(12'h024, "R8 random address");
        crd(12'h020, "R8 random syndrome");
        cw(12'h00C, 32'h3);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule